// File: doc/BRIEF.md
# Dual-Core Physical Address Remapper and Window Decoder

This block sits on the request path between two processor cores and the system interconnect. Each core presents a 36-bit physical request address, which covers a 64 GB space. For each valid request the block returns the address to use on the interconnect and a 4-bit code that names the target. The result appears one clock cycle after the request, and both cores are handled in parallel.

Core 1 can be given a private copy of low memory, which holds its exception vectors. A strap input is captured while reset is held. When it is captured high, any core 1 address in the lowest 256 MB is moved up by 256 MB. Core 0 is never moved. After this step, eight programmable windows decode the address. Each window has a base, a power-of-two size and a target code. When more than one window matches, the lowest-numbered window wins. A fixed boot range falls back to the local bus, so the block can fetch boot code before software has programmed any window. An address that no window claims produces a "none" target and a one-cycle error pulse.

Top module: `dual_core_addr_decoder`

## Requirements
- R1: With the captured offset strap high, a valid core 1 request whose address bits 35:28 are all zero is returned with 0x0_1000_0000 added (for example, 0x0_0000_0100 becomes 0x0_1000_0100).
- R2: A core 0 request address is returned unchanged, whatever the strap.
- R3: A core 1 address with any of bits 35:28 set is returned unchanged.
- R4: The strap value is captured on every clock edge while rst_n is low and held after reset is released. Changing the strap pin after release has no effect on remapping until the next reset. When the captured strap is low, core 1 addresses are returned unchanged.
- R5: With no window enabled, a post-remap address whose bits 35:23 equal 0x1FF (0x0_FF80_0000 to 0x0_FFFF_FFFF) returns target 4'h1 (local bus) with no error.
- R6: A window is written through the write port as index, base bits 35:12, size code S and target code. An enabled window matches an address when address bits 35:max(S,12) equal the same base bits. The window size is therefore 2^S bytes, with 4 KB as the minimum, and base bits below the size are ignored. A match returns the window's target code.
- R7: When several enabled windows match, the target of the lowest-numbered one is returned.
- R8: A window whose enable bit is written as 0 never matches. An enabled window that covers the boot range takes precedence over the local bus fallback.
- R9: A valid request that matches no enabled window and lies outside the boot range returns target 4'hF and raises rsp_err for that core for exactly the response cycle.
- R10: rsp_valid for each core equals that core's req_valid from one cycle earlier. rsp_err is low whenever rsp_valid is low.
- R11: Window matching uses the address after the remap step, so a remapped core 1 request is decoded at its relocated address.
- R12: While rst_n is low, all windows are disabled and the outputs show rsp_valid=0, rsp_err=0, rsp_tgt=4'hF and rsp_addr=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_low_offset | input | 1 | Core 1 low-memory offset strap, captured during reset |
| req_valid | input | 2 | Request valid, one bit per core |
| req_addr | input | 2x36 | Request physical address per core |
| wr_en | input | 1 | Window register write strobe |
| wr_idx | input | 3 | Window index to write |
| wr_base | input | 24 | Window base address bits 35:12 |
| wr_size | input | 6 | Window size code, log2 of the size in bytes |
| wr_tgt | input | 4 | Window target code |
| wr_win_en | input | 1 | Window enable bit to write |
| rsp_valid | output | 2 | Response valid per core |
| rsp_addr | output | 2x36 | Translated address per core |
| rsp_tgt | output | 2x4 | Target code per core |
| rsp_err | output | 2 | Decode error pulse per core |

## Verification
The hardest case to reach is the interaction between the remap and the windows. A core 1 request must fail to match a window that covers its original address and instead hit a different window at the relocated address. In the same cycle, core 0 sends the same original address and must still hit the first window. The bench first sweeps every 128 MB region of the 64 GB space, with both edge offsets in each region, plus every single-bit address. It repeats the sweep with an empty table, then with overlapping, disabled, misaligned-base and boot-covering windows. Both cores are driven with different addresses in every cycle. The strap capture is tested by toggling the strap pin after reset release and across a second reset.

// File: rtl/addr_map_pkg.sv
// Package: shared target codes and the target type for the address decoder.
// Assumes a 4-bit target code. The value 4'hF is reserved for "no target".
package addr_map_pkg;
    localparam int TGT_W = 4;
    typedef logic [TGT_W-1:0] tgt_t;
    localparam tgt_t TGT_DRAM = 4'h0;
    localparam tgt_t TGT_LBUS = 4'h1;
    localparam tgt_t TGT_PCIE = 4'h2;
    localparam tgt_t TGT_SRIO = 4'h3;
    localparam tgt_t TGT_NONE = 4'hF;
endpackage

// File: rtl/low_mem_remap.sv
// Module: low_mem_remap
// Moves an address in the lowest 2^WIN_SHIFT bytes up by 2^WIN_SHIFT.
// The move happens only when this instance is CAPABLE and the captured
// offset enable is set. Only the bits above WIN_SHIFT are decoded.
// Purely combinational; the caller registers the result.
module low_mem_remap #(
    parameter int ADDR_W    = 36,
    parameter int WIN_SHIFT = 28,
    parameter bit CAPABLE   = 1'b0
) (
    input  logic              offset_en,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] OFFSET = ADDR_W'(1) << WIN_SHIFT;

    logic in_low_win;
    logic active;

    // Detect the low window from the upper bits only.
    assign in_low_win = (addr_i[ADDR_W-1:WIN_SHIFT] == '0);
    assign active     = CAPABLE && offset_en && in_low_win;

    // Apply the fixed offset when the remap is active.
    always_comb begin
        addr_o = active ? (addr_i + OFFSET) : addr_i;
    end
endmodule

// File: rtl/law_regfile.sv
// Module: law_regfile
// Holds the programmable window table: page-granular base, size code,
// target and enable for each window. A write updates one window in the
// next cycle. Reset clears every enable.
module law_regfile
    import addr_map_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int PAGE_W  = 24,
    parameter int SIZE_W  = 6,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [PAGE_W-1:0]              wr_base,
    input  logic [SIZE_W-1:0]              wr_size,
    input  tgt_t                           wr_tgt,
    input  logic                           wr_win_en,
    output logic [NUM_WIN-1:0][PAGE_W-1:0] win_base,
    output logic [NUM_WIN-1:0][SIZE_W-1:0] win_size,
    output tgt_t [NUM_WIN-1:0]             win_tgt,
    output logic [NUM_WIN-1:0]             win_en
);
    // Store one window per write; reset disables all windows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_base <= '0;
            win_size <= '0;
            win_tgt  <= {NUM_WIN{TGT_NONE}};
            win_en   <= '0;
        end else if (wr_en && (int'(wr_idx) < NUM_WIN)) begin
            win_base[wr_idx] <= wr_base;
            win_size[wr_idx] <= wr_size;
            win_tgt[wr_idx]  <= wr_tgt;
            win_en[wr_idx]   <= wr_win_en;
        end
    end

    // R12: any reset cycle leaves the table fully disabled.
    p_table_clear_r12: assert property (@(posedge clk)
        !rst_n |=> (win_en == '0));
endmodule

// File: rtl/law_match.sv
// Module: law_match
// Decodes one page address against the window table. Each window compares
// the page bits at or above its size. The lowest-numbered hit wins. With
// no hit, the boot range falls back to the local bus, and anything else
// reports a miss. Purely combinational.
module law_match
    import addr_map_pkg::*;
#(
    parameter int NUM_WIN    = 8,
    parameter int PAGE_SHIFT = 12,
    parameter int PAGE_W     = 24,
    parameter int SIZE_W     = 6,
    parameter int BOOT_SHIFT = 23,
    parameter logic [PAGE_W-1:0] BOOT_PAGE = 24'hFF800,
    localparam int BOOT_LO   = BOOT_SHIFT - PAGE_SHIFT
) (
    input  logic [PAGE_W-1:0]              page_i,
    input  logic [NUM_WIN-1:0][PAGE_W-1:0] win_base,
    input  logic [NUM_WIN-1:0][SIZE_W-1:0] win_size,
    input  tgt_t [NUM_WIN-1:0]             win_tgt,
    input  logic [NUM_WIN-1:0]             win_en,
    output tgt_t                           tgt_o,
    output logic                           miss_o
);
    logic [NUM_WIN-1:0]             hit;
    logic [NUM_WIN-1:0][PAGE_W-1:0] care;
    logic                           pick_any;
    tgt_t                           pick_tgt;
    logic                           in_boot;

    // Per-window compare: a page bit counts only at or above the size code.
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        for (genvar j = 0; j < PAGE_W; j++) begin : g_bit
            assign care[w][j] = ((j + PAGE_SHIFT) >= int'(win_size[w]));
        end
        assign hit[w] = win_en[w] && (((page_i ^ win_base[w]) & care[w]) == '0);
    end

    // Priority pick: scan downward so the lowest index is written last.
    always_comb begin
        pick_any = 1'b0;
        pick_tgt = TGT_NONE;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (hit[w]) begin
                pick_any = 1'b1;
                pick_tgt = win_tgt[w];
            end
        end
    end

    // Boot fallback decode on the upper page bits.
    assign in_boot = (page_i[PAGE_W-1:BOOT_LO] == BOOT_PAGE[PAGE_W-1:BOOT_LO]);

    // Final target and miss selection.
    always_comb begin
        if (pick_any) begin
            tgt_o  = pick_tgt;
            miss_o = 1'b0;
        end else if (in_boot) begin
            tgt_o  = TGT_LBUS;
            miss_o = 1'b0;
        end else begin
            tgt_o  = TGT_NONE;
            miss_o = 1'b1;
        end
    end
endmodule

// File: rtl/dual_core_addr_decoder.sv
// Module: dual_core_addr_decoder (top)
// Per core, this module remaps the address (core 1 only), then decodes it
// against the shared window table. The address, target and error are
// registered one cycle after the request. The offset enable is captured
// from the strap while reset is low. Assumes two cores.
module dual_core_addr_decoder
    import addr_map_pkg::*;
#(
    parameter int ADDR_W        = 36,
    parameter int NUM_WIN       = 8,
    parameter int SIZE_W        = 6,
    parameter int PAGE_SHIFT    = 12,
    parameter int LOW_WIN_SHIFT = 28,
    parameter int BOOT_SHIFT    = 23,
    parameter logic [ADDR_W-1:0] BOOT_BASE = 36'h0_FF80_0000,
    localparam int IDX_W        = $clog2(NUM_WIN),
    localparam int PAGE_W       = ADDR_W - PAGE_SHIFT,
    localparam int NUM_CORES    = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             strap_low_offset,
    input  logic [NUM_CORES-1:0]             req_valid,
    input  logic [NUM_CORES-1:0][ADDR_W-1:0] req_addr,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [PAGE_W-1:0]                wr_base,
    input  logic [SIZE_W-1:0]                wr_size,
    input  logic [TGT_W-1:0]                 wr_tgt,
    input  logic                             wr_win_en,
    output logic [NUM_CORES-1:0]             rsp_valid,
    output logic [NUM_CORES-1:0][ADDR_W-1:0] rsp_addr,
    output logic [NUM_CORES-1:0][TGT_W-1:0]  rsp_tgt,
    output logic [NUM_CORES-1:0]             rsp_err
);
    localparam logic [ADDR_W-1:0] LOW_OFFSET = ADDR_W'(1) << LOW_WIN_SHIFT;

    logic                           offset_en;
    logic [NUM_WIN-1:0][PAGE_W-1:0] win_base;
    logic [NUM_WIN-1:0][SIZE_W-1:0] win_size;
    tgt_t [NUM_WIN-1:0]             win_tgt;
    logic [NUM_WIN-1:0]             win_en;
    logic [NUM_CORES-1:0][ADDR_W-1:0] mapped;
    tgt_t [NUM_CORES-1:0]           dec_tgt;
    logic [NUM_CORES-1:0]           dec_miss;

    // Capture the strap during reset and hold it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) offset_en <= strap_low_offset;
    end

    law_regfile #(
        .NUM_WIN(NUM_WIN), .PAGE_W(PAGE_W), .SIZE_W(SIZE_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_base(wr_base), .wr_size(wr_size), .wr_tgt(wr_tgt),
        .wr_win_en(wr_win_en), .win_base(win_base), .win_size(win_size),
        .win_tgt(win_tgt), .win_en(win_en)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        low_mem_remap #(
            .ADDR_W(ADDR_W), .WIN_SHIFT(LOW_WIN_SHIFT), .CAPABLE(c == 1)
        ) u_remap (
            .offset_en(offset_en), .addr_i(req_addr[c]), .addr_o(mapped[c])
        );

        law_match #(
            .NUM_WIN(NUM_WIN), .PAGE_SHIFT(PAGE_SHIFT), .PAGE_W(PAGE_W),
            .SIZE_W(SIZE_W), .BOOT_SHIFT(BOOT_SHIFT),
            .BOOT_PAGE(BOOT_BASE[ADDR_W-1:PAGE_SHIFT])
        ) u_match (
            .page_i(mapped[c][ADDR_W-1:PAGE_SHIFT]), .win_base(win_base),
            .win_size(win_size), .win_tgt(win_tgt), .win_en(win_en),
            .tgt_o(dec_tgt[c]), .miss_o(dec_miss[c])
        );

        // Register this core's response one cycle after the request.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rsp_valid[c] <= 1'b0;
                rsp_addr[c]  <= '0;
                rsp_tgt[c]   <= TGT_NONE;
                rsp_err[c]   <= 1'b0;
            end else begin
                rsp_valid[c] <= req_valid[c];
                rsp_addr[c]  <= mapped[c];
                rsp_tgt[c]   <= dec_tgt[c];
                rsp_err[c]   <= req_valid[c] && dec_miss[c];
            end
        end

        // R10: a request yields a response in the next cycle.
        p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid[c] |=> rsp_valid[c]);
        // R10: no request means no response and no error.
        p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid[c] |=> (!rsp_valid[c] && !rsp_err[c]));
        // R9: an error is only reported with a valid "none" response.
        p_err_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_err[c] |-> (rsp_valid[c] && rsp_tgt[c] == TGT_NONE));
    end

    // R2: core 0 addresses pass unchanged.
    p_core0_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid[0] |=> (rsp_addr[0] == $past(req_addr[0])));
    // R1: core 1 low-window addresses move up by the fixed offset.
    p_core1_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid[1] && offset_en && req_addr[1][ADDR_W-1:LOW_WIN_SHIFT] == '0)
        |=> (rsp_addr[1] == $past(req_addr[1]) + LOW_OFFSET));
    // R3: core 1 addresses above the low window pass unchanged.
    p_core1_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid[1] && req_addr[1][ADDR_W-1:LOW_WIN_SHIFT] != '0)
        |=> (rsp_addr[1] == $past(req_addr[1])));
    // R5: with an empty table, the boot range goes to the local bus.
    p_boot_default_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid[0] && win_en == '0 &&
         req_addr[0][ADDR_W-1:BOOT_SHIFT] == BOOT_BASE[ADDR_W-1:BOOT_SHIFT])
        |=> (rsp_tgt[0] == TGT_LBUS && !rsp_err[0]));
    // R4: the captured offset enable does not move outside reset.
    p_strap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(offset_en));
endmodule

// File: tb/dual_core_addr_decoder_test.sv
// Bench for dual_core_addr_decoder. It sweeps addresses over both cores
// against table configurations that the bench keeps in its own shadow
// copy, and computes the expected address and target arithmetically.
module dual_core_addr_decoder_test;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              strap = 1'b1;
    logic [1:0]        req_valid = '0;
    logic [1:0][35:0]  req_addr = '0;
    logic              wr_en = 1'b0;
    logic [2:0]        wr_idx = '0;
    logic [23:0]       wr_base = '0;
    logic [5:0]        wr_size = '0;
    logic [3:0]        wr_tgt = '0;
    logic              wr_win_en = 1'b0;
    logic [1:0]        rsp_valid;
    logic [1:0][35:0]  rsp_addr;
    logic [1:0][3:0]   rsp_tgt;
    logic [1:0]        rsp_err;

    int checks = 0;
    int failures = 0;
    logic [35:0] sh_base [8];
    int          sh_size [8];
    logic [3:0]  sh_tgt  [8];
    logic        sh_en   [8];
    logic        sh_off;
    localparam int NSWEEP = 1024 + 36 + 8;

    always #2 clk = ~clk;

    dual_core_addr_decoder uut (
        .clk(clk), .rst_n(rst_n), .strap_low_offset(strap),
        .req_valid(req_valid), .req_addr(req_addr), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_base(wr_base), .wr_size(wr_size),
        .wr_tgt(wr_tgt), .wr_win_en(wr_win_en), .rsp_valid(rsp_valid),
        .rsp_addr(rsp_addr), .rsp_tgt(rsp_tgt), .rsp_err(rsp_err)
    );

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [35:0] addr_of(input int k);
        if (k < 512) return 36'(k) << 27;
        if (k < 1024) return (36'(k - 512) << 27) | 36'h7FF_FFFF;
        if (k < 1060) return 36'(1) << (k - 1024);
        case (k - 1060)
            0: return 36'h0_0000_0100;
            1: return 36'h0_0000_1600;
            2: return 36'h0_0FFF_FFFF;
            3: return 36'h0_1000_0000;
            4: return 36'h0_FF7F_FFFF;
            5: return 36'h0_FF80_0000;
            6: return 36'h0_FFFF_FFFF;
            default: return 36'h1_FF80_0000;
        endcase
    endfunction

    // Decode from the shadow table: lowest index first, then boot, else none.
    task automatic model(input logic [35:0] a, output logic [3:0] t,
                         output logic e, output string tag);
        int nh = 0;
        t = 4'hF; e = 1'b0;
        for (int w = 7; w >= 0; w--) begin
            int sz = (sh_size[w] < 12) ? 12 : ((sh_size[w] > 36) ? 36 : sh_size[w]);
            if (sh_en[w] && ((a >> sz) == (sh_base[w] >> sz))) begin
                nh++; t = sh_tgt[w];
            end
        end
        if (nh > 1) tag = "R7";
        else if (nh == 1) tag = "R6";
        else if (a[35:23] == 13'h1FF) begin t = 4'h1; tag = "R5"; end
        else begin e = 1'b1; tag = "R9"; end
    endtask

    task automatic check_core(input int c, input logic [35:0] a);
        logic [35:0] ea; logic [3:0] et; logic ee; string ttag; string atag;
        ea = a; atag = (c == 0) ? "R2" : "R3";
        if (c == 1 && a[35:28] == 8'h0) begin
            if (sh_off) begin ea = a + 36'h0_1000_0000; atag = "R1"; end
            else atag = "R4";
        end
        model(ea, et, ee, ttag);
        if (ea != a && ttag != "R9") ttag = "R11";
        chk(rsp_valid[c] == 1'b1, "R10", "valid", 36'(rsp_valid[c]), 36'h1);
        chk(rsp_addr[c] == ea, atag, "addr", rsp_addr[c], ea);
        chk(rsp_tgt[c] == et, ttag, "tgt", 36'(rsp_tgt[c]), 36'(et));
        chk(rsp_err[c] == ee, ee ? "R9" : ttag, "err", 36'(rsp_err[c]), 36'(ee));
    endtask

    task automatic req2(input logic [35:0] a0, input logic [35:0] a1);
        req_valid = 2'b11; req_addr[0] = a0; req_addr[1] = a1;
        @(posedge clk); #1;
        check_core(0, a0); check_core(1, a1);
        req_valid = 2'b00;
    endtask

    task automatic sweep();
        for (int k = 0; k < NSWEEP; k++) req2(addr_of(k), addr_of((k * 7 + 3) % NSWEEP));
    endtask

    task automatic wr(input int idx, input logic [35:0] base, input int size,
                      input logic [3:0] tgt, input logic en);
        wr_en = 1'b1; wr_idx = 3'(idx); wr_base = base[35:12];
        wr_size = 6'(size); wr_tgt = tgt; wr_win_en = en;
        @(posedge clk); #1;
        wr_en = 1'b0;
        sh_base[idx] = base; sh_size[idx] = size; sh_tgt[idx] = tgt; sh_en[idx] = en;
    endtask

    task automatic do_reset(input logic s);
        strap = s; rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R12: outputs and table held at their reset values.
        for (int c = 0; c < 2; c++) begin
            chk(rsp_valid[c] == 1'b0, "R12", "rst valid", 36'(rsp_valid[c]), 36'h0);
            chk(rsp_err[c] == 1'b0, "R12", "rst err", 36'(rsp_err[c]), 36'h0);
            chk(rsp_tgt[c] == 4'hF, "R12", "rst tgt", 36'(rsp_tgt[c]), 36'hF);
            chk(rsp_addr[c] == '0, "R12", "rst addr", rsp_addr[c], 36'h0);
        end
        for (int w = 0; w < 8; w++) begin
            sh_en[w] = 1'b0; sh_base[w] = '0; sh_size[w] = 0; sh_tgt[w] = 4'hF;
        end
        sh_off = s; rst_n = 1'b1;
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog expired R10 actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset(1'b1);
        sweep();                                       // R1 R2 R3 R5 R9 on empty table
        wr(0, 36'h0_0000_0000, 28, 4'h0, 1'b1);        // DRAM low 256 MB
        wr(1, 36'h0_1000_0000, 28, 4'h2, 1'b1);        // relocated region, R11
        wr(2, 36'h0_0000_0000, 36, 4'h5, 1'b0);        // disabled catch-all, R8
        wr(3, 36'h8_0000_0000, 35, 4'h3, 1'b1);        // upper 32 GB
        wr(4, 36'h4_0000_1234, 20, 4'h4, 1'b1);        // misaligned base, R6
        wr(5, 36'h0_FF80_0000, 23, 4'h6, 1'b1);        // covers boot, R8
        wr(6, 36'h2_0000_0000, 16, 4'h8, 1'b1);        // overlaps window 7, R7
        wr(7, 36'h2_0000_3000, 12, 4'h7, 1'b1);
        sweep();
        req2(36'h2_0000_3abc, 36'h2_0000_3000);        // R7 overlap on both cores
        req2(36'h4_000F_FFFF, 36'h4_0010_0000);        // R6 size edge
        req2(36'h0_FF80_0000, 36'h0_0000_1600);        // R8 window over boot, R11
        wr(5, 36'h0_FF80_0000, 23, 4'h6, 1'b0);        // disable boot-covering window
        req2(36'h0_FFFF_FFFF, 36'h4_1000_0000);        // R8: fallback back to LBUS; disabled catch-all misses
        // R10/R9: idle cycle after a miss shows no response and no error.
        @(posedge clk); #1;
        for (int c = 0; c < 2; c++) begin
            chk(rsp_valid[c] == 1'b0, "R10", "idle valid", 36'(rsp_valid[c]), 36'h0);
            chk(rsp_err[c] == 1'b0, "R9", "err pulse end", 36'(rsp_err[c]), 36'h0);
        end
        // R4: strap change after release does not stop the remap.
        strap = 1'b0;
        repeat (2) @(posedge clk); #1;
        req2(36'h0_0000_0100, 36'h0_0000_0100);
        // R4 and R12: new reset with strap low; table cleared.
        do_reset(1'b0);
        req2(36'h0_0000_0100, 36'h0_0000_0100);
        strap = 1'b1;
        repeat (2) @(posedge clk); #1;
        req2(36'h0_0FFF_FFFF, 36'h0_0000_1600);
        wr(0, 36'h0_0000_0000, 28, 4'h0, 1'b1);
        sweep();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule